// File: doc/BRIEF.md
# Spindle Command and Brake Controller

This block turns a signed 12-bit spindle command and a measured rotor speed into a drive mode and a PWM duty value. Positive commands accelerate the motor with a duty of six times the command, saturated at full scale. Negative commands decelerate it. The brake style depends on how large the command is and whether the rotor is spinning fast or slow. The block drives no power stage itself. A commutation stage downstream reads the mode code and the duty value.

The rotor speed is estimated from a tachometer signal. This signal is the exclusive-OR of the three hall/back-EMF phase bits. The block measures the period between falling edges of that signal in timebase ticks. Two period thresholds define the fast and slow speed bands. Between the thresholds the previous speed decision is kept, which gives hysteresis. A long low interval on the tachometer signal counts as a stalled rotor and forces a short brake. A low-speed mode caps the duty at a quarter of full scale and turns every brake request into a short brake.

Top module: `spin_brake_ctrl`

## Requirements
- R1: While rst_ni is low, mode_o is 0, duty_o is 0 and fg_o is 1. mode_o and duty_o are registered, so they reflect the inputs present one clock earlier.
- R2: The mode codes are idle=0, accelerate=1, active brake=2, two-phase short brake=3 and three-phase short brake=4. A command of 0x000 to 0x052 gives idle. A command of 0xFAE to 0xFFF (-82 to -1) gives two-phase short brake. Both cases have duty 0.
- R3: A command of 0x053 to 0x7FF gives accelerate with duty = min(6*cmd, 4095).
- R4: A command of 0xA01 to 0xFAD (magnitude 83 to 1535) gives active brake with duty = min(6*|cmd|, 4095).
- R5: A command of 0x800 to 0xA00 (magnitude 1536 to 2048) depends on speed. When the rotor is fast it gives three-phase short brake with duty 0. When the rotor is slow it gives active brake with duty = min(6*|cmd|, 4095).
- R6: The speed state is updated at each FG falling edge, using the count of ticks since the previous falling edge. A count below FAST_PER sets fast. A count above SLOW_PER sets slow. Any other count keeps the previous state. If more than SLOW_PER ticks pass with no falling edge, the state becomes slow. The state is slow after reset.
- R7: Once FG has been low for STALL_TICKS ticks, any brake request (cmd from 0x800 to 0xFAD) gives two-phase short brake with duty 0. Acceleration is not affected.
- R8: With low_speed_i set, duty_o never exceeds 1023, and every brake request gives two-phase short brake.
- R9: fg_o equals the exclusive-OR of phase_i, registered one clock. fg_o is forced to 1 while sleep_i is set.
- R10: The period and low-interval counters advance only in cycles where tick_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 12 | Signed spindle command, two's complement |
| phase_i | input | 3 | Hall/back-EMF phase bits |
| low_speed_i | input | 1 | Low-speed mode: quarter duty cap, short braking only |
| sleep_i | input | 1 | Sleep: forces FG high |
| tick_i | input | 1 | Timebase tick for the speed and stall counters |
| mode_o | output | 3 | Drive mode code |
| duty_o | output | 12 | PWM duty magnitude |
| fg_o | output | 1 | Tachometer output |

## Verification
A table of commands is walked with the rotor held slow and the tachometer held high. Its entries sit on both sides of each region edge (±0x52/0x53, 0xFAE/0xFAD, 0xA01/0xA00, and the 4095 saturation point), which separates the dead band, the two brake regions and the gain and saturation arithmetic. The same table is then repeated in low-speed mode to show the quarter cap and the forced short brakes. Tachometer trains with short, medium and long periods are played in sequences such as fast then medium, and slow then medium. The command is held at 0x900 during these trains, so three-phase versus active brake shows whether the hysteresis kept or changed the speed decision. Held low and high phases then expose the stall override and the no-edge timeout. Repeating the held-low phase with the tick input at 0 shows that the counters stop without it.

// File: rtl/spin_pkg.sv
package spin_pkg;
  typedef enum logic [2:0] {
    MODE_IDLE   = 3'd0,
    MODE_ACCEL  = 3'd1,
    MODE_ACTIVE = 3'd2,
    MODE_SHORT2 = 3'd3,
    MODE_SHORT3 = 3'd4
  } spin_mode_e;
endpackage

// File: rtl/spin_fg_speed.sv
module spin_fg_speed #(
  parameter int CNT_W       = 16,
  parameter int FAST_PER    = 20,
  parameter int SLOW_PER    = 30,
  parameter int STALL_TICKS = 300
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] phase_i,
  input  logic       tick_i,
  output logic       fg_raw_o,
  output logic       fast_o,
  output logic       stall_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] FAST_C  = CNT_W'(FAST_PER);
  localparam logic [CNT_W-1:0] SLOW_C  = CNT_W'(SLOW_PER);
  localparam logic [CNT_W-1:0] STALL_C = CNT_W'(STALL_TICKS);

  logic             fg_q;
  logic             fall;
  logic [CNT_W-1:0] per_cnt_q;
  logic [CNT_W-1:0] low_cnt_q;
  logic             fast_q;

  assign fg_raw_o = ^phase_i;
  assign fall     = fg_q & ~fg_raw_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fg_q      <= 1'b0;
      per_cnt_q <= '0;
      low_cnt_q <= '0;
      fast_q    <= 1'b0;
    end else begin
      fg_q <= fg_raw_o;
      // period since last falling edge, saturating
      if (fall)
        per_cnt_q <= '0;
      else if (tick_i && per_cnt_q != CNT_MAX)
        per_cnt_q <= per_cnt_q + 1'b1;
      // hysteretic band decision
      if (fall) begin
        if (per_cnt_q < FAST_C)      fast_q <= 1'b1;
        else if (per_cnt_q > SLOW_C) fast_q <= 1'b0;
      end else if (per_cnt_q > SLOW_C) begin
        fast_q <= 1'b0;
      end
      // continuous low interval
      if (fg_raw_o)
        low_cnt_q <= '0;
      else if (tick_i && low_cnt_q != CNT_MAX)
        low_cnt_q <= low_cnt_q + 1'b1;
    end
  end

  assign fast_o  = fast_q;
  assign stall_o = (low_cnt_q >= STALL_C);
endmodule

// File: rtl/spin_mode_dec.sv
module spin_mode_dec
  import spin_pkg::*;
#(
  parameter int CMD_W     = 12,
  parameter int DEAD_BAND = 82,
  parameter int SPLIT_MAG = 1536
) (
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             low_speed_i,
  input  logic             fast_i,
  input  logic             stall_i,
  output spin_mode_e       mode_o,
  output logic [CMD_W-1:0] mag_o,
  output logic             drive_o
);
  localparam logic [CMD_W-1:0] DEAD_C  = CMD_W'(DEAD_BAND);
  localparam logic [CMD_W-1:0] SPLIT_C = CMD_W'(SPLIT_MAG);

  logic neg;

  assign neg   = cmd_i[CMD_W-1];
  assign mag_o = neg ? (~cmd_i + 1'b1) : cmd_i;

  always_comb begin
    if (!neg) begin
      mode_o = (mag_o <= DEAD_C) ? MODE_IDLE : MODE_ACCEL;
    end else if (mag_o <= DEAD_C || low_speed_i || stall_i) begin
      mode_o = MODE_SHORT2;
    end else if (mag_o >= SPLIT_C) begin
      mode_o = fast_i ? MODE_SHORT3 : MODE_ACTIVE;
    end else begin
      mode_o = MODE_ACTIVE;
    end
  end

  assign drive_o = (mode_o == MODE_ACCEL) || (mode_o == MODE_ACTIVE);
endmodule

// File: rtl/spin_duty_calc.sv
module spin_duty_calc #(
  parameter int CMD_W  = 12,
  parameter int DUTY_W = 12,
  parameter int GAIN   = 6
) (
  input  logic [CMD_W-1:0]  mag_i,
  input  logic              drive_i,
  input  logic              low_speed_i,
  output logic [DUTY_W-1:0] duty_o
);
  localparam int PROD_W = CMD_W + $clog2(GAIN + 1);
  localparam logic [DUTY_W-1:0] FULL_C = {DUTY_W{1'b1}};
  localparam logic [DUTY_W-1:0] LS_C   = FULL_C >> 2;

  logic [PROD_W-1:0] prod;
  logic [DUTY_W-1:0] cap;

  assign prod = PROD_W'(mag_i) * PROD_W'(GAIN);
  assign cap  = low_speed_i ? LS_C : FULL_C;

  always_comb begin
    if (!drive_i)
      duty_o = '0;
    else if (prod > PROD_W'(cap))
      duty_o = cap;
    else
      duty_o = prod[DUTY_W-1:0];
  end
endmodule

// File: rtl/spin_brake_ctrl.sv
module spin_brake_ctrl
  import spin_pkg::*;
#(
  parameter int CMD_W       = 12,
  parameter int DUTY_W      = 12,
  parameter int GAIN        = 6,
  parameter int DEAD_BAND   = 82,
  parameter int SPLIT_MAG   = 1536,
  parameter int CNT_W       = 16,
  parameter int FAST_PER    = 20,
  parameter int SLOW_PER    = 30,
  parameter int STALL_TICKS = 300
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [2:0]        phase_i,
  input  logic              low_speed_i,
  input  logic              sleep_i,
  input  logic              tick_i,
  output logic [2:0]        mode_o,
  output logic [DUTY_W-1:0] duty_o,
  output logic              fg_o
);
  logic              fg_raw, fast, stall, drive;
  logic [CMD_W-1:0]  mag;
  logic [DUTY_W-1:0] duty_d;
  spin_mode_e        mode_d;
  spin_mode_e        mode_q;
  logic [DUTY_W-1:0] duty_q;
  logic              fg_q;

  spin_fg_speed #(
    .CNT_W(CNT_W), .FAST_PER(FAST_PER), .SLOW_PER(SLOW_PER), .STALL_TICKS(STALL_TICKS)
  ) u_speed (
    .clk_i(clk_i), .rst_ni(rst_ni), .phase_i(phase_i), .tick_i(tick_i),
    .fg_raw_o(fg_raw), .fast_o(fast), .stall_o(stall)
  );

  spin_mode_dec #(
    .CMD_W(CMD_W), .DEAD_BAND(DEAD_BAND), .SPLIT_MAG(SPLIT_MAG)
  ) u_dec (
    .cmd_i(cmd_i), .low_speed_i(low_speed_i), .fast_i(fast), .stall_i(stall),
    .mode_o(mode_d), .mag_o(mag), .drive_o(drive)
  );

  spin_duty_calc #(
    .CMD_W(CMD_W), .DUTY_W(DUTY_W), .GAIN(GAIN)
  ) u_duty (
    .mag_i(mag), .drive_i(drive), .low_speed_i(low_speed_i), .duty_o(duty_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_IDLE;
      duty_q <= '0;
      fg_q   <= 1'b1;
    end else begin
      mode_q <= mode_d;
      duty_q <= duty_d;
      fg_q   <= sleep_i | fg_raw;
    end
  end

  assign mode_o = mode_q;
  assign duty_o = duty_q;
  assign fg_o   = fg_q;
endmodule

// File: rtl/spin_brake_ctrl_chk.sv
module spin_brake_ctrl_chk
  import spin_pkg::*;
#(
  parameter int CMD_W     = 12,
  parameter int DUTY_W    = 12,
  parameter int DEAD_BAND = 82
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CMD_W-1:0]  cmd_i,
  input logic [2:0]        phase_i,
  input logic              low_speed_i,
  input logic              sleep_i,
  input logic [2:0]        mode_o,
  input logic [DUTY_W-1:0] duty_o,
  input logic              fg_o
);
  localparam logic [DUTY_W-1:0] LS_CAP = {DUTY_W{1'b1}} >> 2;
  int cmd_val;
  assign cmd_val = int'($signed(cmd_i));

  // R9
  sleep_fg_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> fg_o);
  // R9
  fg_xor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_i |=> (fg_o == $past(^phase_i)));
  // R2
  dead_band_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_val <= DEAD_BAND && cmd_val >= -DEAD_BAND) |=> (duty_o == '0));
  // R3
  accel_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_val > DEAD_BAND) |=> (mode_o == 3'(MODE_ACCEL)));
  // R8
  ls_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_speed_i |=> (duty_o <= LS_CAP));
  // R8
  ls_short_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_speed_i && cmd_val < -DEAD_BAND) |=> (mode_o == 3'(MODE_SHORT2)));
  // R5
  short_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'(MODE_SHORT2) || mode_o == 3'(MODE_SHORT3) || mode_o == 3'(MODE_IDLE))
      |-> (duty_o == '0));
  // R2
  mode_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o <= 3'd4);
endmodule

bind spin_brake_ctrl spin_brake_ctrl_chk #(
  .CMD_W(CMD_W), .DUTY_W(DUTY_W), .DEAD_BAND(DEAD_BAND)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd_i), .phase_i(phase_i),
  .low_speed_i(low_speed_i), .sleep_i(sleep_i), .mode_o(mode_o),
  .duty_o(duty_o), .fg_o(fg_o)
);

// File: tb/sim_spin_brake_ctrl.sv
`timescale 1ns/1ps
module sim_spin_brake_ctrl;
  localparam int IDLE = 0, ACCEL = 1, ACTIVE = 2, SHORT2 = 3, SHORT3 = 4;
  localparam int NV = 20;
  // {low_speed, cmd, mode, duty}
  localparam logic [27:0] VEC [NV] = '{
    {1'b0, 12'h000, 3'd0, 12'd0},
    {1'b0, 12'h052, 3'd0, 12'd0},
    {1'b0, 12'h053, 3'd1, 12'd498},
    {1'b0, 12'h100, 3'd1, 12'd1536},
    {1'b0, 12'h2AA, 3'd1, 12'd4092},
    {1'b0, 12'h2AB, 3'd1, 12'd4095},
    {1'b0, 12'h7FF, 3'd1, 12'd4095},
    {1'b0, 12'hFFF, 3'd3, 12'd0},
    {1'b0, 12'hFAE, 3'd3, 12'd0},
    {1'b0, 12'hFAD, 3'd2, 12'd498},
    {1'b0, 12'hF00, 3'd2, 12'd1536},
    {1'b0, 12'hC00, 3'd2, 12'd4095},
    {1'b0, 12'hA01, 3'd2, 12'd4095},
    {1'b0, 12'hA00, 3'd2, 12'd4095},
    {1'b0, 12'h800, 3'd2, 12'd4095},
    {1'b1, 12'h100, 3'd1, 12'd1023},
    {1'b1, 12'h053, 3'd1, 12'd498},
    {1'b1, 12'hC00, 3'd3, 12'd0},
    {1'b1, 12'h900, 3'd3, 12'd0},
    {1'b1, 12'h052, 3'd0, 12'd0}
  };

  logic        clk = 0, rst_n = 0;
  logic [11:0] cmd = '0;
  logic [2:0]  phase = 3'b001;
  logic        ls = 0, sleep = 0, tick = 1;
  logic [2:0]  mode;
  logic [11:0] duty;
  logic        fg;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  spin_brake_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .phase_i(phase),
    .low_speed_i(ls), .sleep_i(sleep), .tick_i(tick),
    .mode_o(mode), .duty_o(duty), .fg_o(fg)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic fg_run(int per, int n);
    for (int k = 0; k < n; k++) begin
      phase = 3'b001; cyc(per / 2);
      phase = 3'b000; cyc(per - per / 2);
    end
  endtask

  initial begin
    cyc(3);
    check("R1 reset mode", mode, IDLE);
    check("R1 reset duty", duty, 0);
    check("R1 reset fg", fg, 1);
    rst_n = 1;
    cyc(2);
    // table walk, rotor slow, FG high
    for (int i = 0; i < NV; i++) begin
      ls = VEC[i][27]; cmd = VEC[i][26:15];
      cyc(1);
      check($sformatf("R2/R3/R4/R5/R8 vec%0d mode", i), mode, int'(VEC[i][14:12]));
      check($sformatf("R2/R3/R4/R5/R8 vec%0d duty", i), duty, int'(VEC[i][11:0]));
    end
    ls = 0;
    // R9 FG
    phase = 3'b011; cyc(1); check("R9 fg xor 011", fg, 0);
    phase = 3'b111; cyc(1); check("R9 fg xor 111", fg, 1);
    sleep = 1; phase = 3'b011; cyc(1); check("R9 sleep forces fg", fg, 1);
    sleep = 0; cyc(1); check("R9 fg after sleep", fg, 0);
    // R6 / R5 hysteresis
    cmd = 12'h900;
    fg_run(10, 4); check("R6 fast band -> R5 short3", mode, SHORT3);
    fg_run(26, 4); check("R6 middle keeps fast", mode, SHORT3);
    fg_run(50, 3); check("R6 slow band -> R5 active", mode, ACTIVE);
    check("R5 slow active duty", duty, 4095);
    fg_run(26, 4); check("R6 middle keeps slow", mode, ACTIVE);
    fg_run(10, 3); check("R6 back to fast", mode, SHORT3);
    phase = 3'b001; cyc(40); check("R6 no-edge timeout slow", mode, ACTIVE);
    // R7 stall
    cmd = 12'hC00; phase = 3'b000; cyc(100);
    check("R7 before stall", mode, ACTIVE);
    cyc(300);
    check("R7 stall short2 mode", mode, SHORT2);
    check("R7 stall short2 duty", duty, 0);
    cmd = 12'h100; cyc(1);
    check("R7 accel unaffected", mode, ACCEL);
    check("R7 accel duty", duty, 1536);
    cmd = 12'hC00; phase = 3'b001; cyc(2);
    check("R7 stall cleared", mode, ACTIVE);
    // R10 tick gating
    tick = 0; phase = 3'b000; cyc(400);
    check("R10 no tick no stall", mode, ACTIVE);
    tick = 1; cyc(320);
    check("R10 tick resumes stall", mode, SHORT2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #750000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule